// File: doc/BRIEF.md
# Keyed Configuration Port for a Four-Channel Serial Controller

This block is the configuration front end of a multi-channel serial I/O controller. The host sees two consecutive byte addresses. The lower address is a pointer port and the upper address is a value port. Register contents are reached by writing a register number to the pointer port and then reading or writing the value port.

All register access is locked after reset. To open it, the host writes a chosen unlock byte to the pointer port twice, with no other write in between. A dedicated close code written to the pointer port locks access again.

While access is open, the pointer can reach three kinds of register:
- a few fixed identity registers;
- a channel selector;
- a bank of per-channel registers, picked by the channel selector.

Each bank holds a 16-bit I/O base address, an interrupt trigger register and a half-duplex line-control register. The contents of every bank are also driven continuously onto output ports, so that the serial channels can use them.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, access is locked. The pointer and the channel selector are 0. Each bank holds its per-channel parameter default, reduced by that register's implemented-bit mask.
- R2: Two successive writes of the parameter `KEY` (default 0x87) to the pointer port (`bus_addr`=0) open access from the next cycle. Read strobes between the two writes do not break the sequence.
- R3: An unlock byte followed by any other write does not open access. The other write may be a different pointer value or any value-port write. A second unlock byte after such a write only re-arms the sequence.
- R4: While locked, reads of either port return 0xFF, and value-port writes change no register.
- R5: While open, writing the close code 0xAA to the pointer port locks access on the next cycle and leaves the pointer unchanged. Any other pointer write loads the pointer, and a read of the pointer port returns it.
- R6: Pointer 0x20 reads the chip identity low byte and 0x21 reads its high byte (parameter `CHIP_ID`, default 0x1602). Pointer 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these four pointers have no effect.
- R7: Pointer 0x07 is the channel selector. A write keeps the low two bits, so 0xFE selects channel 2. A read returns the selected channel number, 0 to 3.
- R8: In the selected bank, pointer 0x60 holds the high byte and 0x61 the low byte of the 16-bit base address. Each channel's value appears on `ch_base` bits [16*ch+15:16*ch].
- R9: Pointer 0x70 is the interrupt trigger register, and only bits 6:4 are kept. Bit 4 enables a shared line. Bits 6:5 = 00 select level active-low, and bit 5 set selects edge active-high. Unkept bits read 0. The value appears on `ch_irq` bits [8*ch+7:8*ch].
- R10: Pointer 0xF0 is the line-control register, and only bits 5:2 are kept. Bit 5 inverts RTS. Bit 4 enables automatic direction control. Bit 3 enables a receive-side wait. Bit 2 enables a transmit-side wait. The value appears on `ch_rs485` bits [8*ch+7:8*ch].
- R11: While open, every pointer value other than those listed in R6 to R10 reads 0x00 at the value port.
- R12: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = pointer port, 1 = value port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from current state |
| ch_base | output | 64 | Base address of each channel, 16 bits per channel |
| ch_irq | output | 32 | Interrupt trigger register of each channel |
| ch_rs485 | output | 32 | Line-control register of each channel |

## Verification
A write strobe acts at the rising edge that sees it, so any lock change, pointer change or register change becomes visible in the following cycle. Read data is combinational: it is valid in the same cycle as the read strobe. The bench drives every strobe at a falling edge and samples read data a short time later, in the same half cycle. It checks the exported bank outputs only after the falling edge that follows the write edge. The unlock logic is swept over all 256 pointer bytes, and every pointer value is read back in each of the four banks.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // register numbers decoded at the value port
    localparam logic [7:0] IDX_CHSEL   = 8'h07;
    localparam logic [7:0] IDX_CHIP_LO = 8'h20;
    localparam logic [7:0] IDX_CHIP_HI = 8'h21;
    localparam logic [7:0] IDX_VEND_A  = 8'h23;
    localparam logic [7:0] IDX_VEND_B  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_LINE    = 8'hF0;

    localparam logic [7:0] VEND_A_VAL  = 8'h19;
    localparam logic [7:0] VEND_B_VAL  = 8'h34;

    // implemented bits of the banked control registers
    localparam logic [7:0] IRQ_MASK    = 8'h70;
    localparam logic [7:0] LINE_MASK   = 8'h3C;

    localparam logic [7:0] LOCKED_READ = 8'hFF;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_e;

    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  irq;
        logic [7:0]  line;
    } bank_t;

endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY       = 8'h87,
    parameter logic [7:0] EXIT_CODE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       any_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);

    typedef struct packed {
        gate_e st;
    } gate_state_t;

    gate_state_t q, d;

    logic key_hit;
    assign key_hit = idx_wr && (wdata == KEY);

    always_comb begin
        d = q;
        case (q.st)
            GATE_LOCKED: if (key_hit) d.st = GATE_ARMED;
            GATE_ARMED: begin
                if (key_hit)     d.st = GATE_OPEN;
                else if (any_wr) d.st = GATE_LOCKED;
            end
            GATE_OPEN: if (idx_wr && wdata == EXIT_CODE) d.st = GATE_LOCKED;
            default: d.st = GATE_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: GATE_LOCKED};
        else        q <= d;
    end

    assign cfg_open = (q.st == GATE_OPEN);

    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(idx_wr) && $past(wdata) == KEY && $past(q.st) == GATE_ARMED)); // R2

    AST_BROKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == GATE_ARMED && any_wr && !(idx_wr && wdata == KEY)) |=> (q.st == GATE_LOCKED)); // R3

    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == EXIT_CODE) |=> !cfg_open); // R5

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_RST = 16'h03F8,
    parameter logic [7:0]  IRQ_RST  = 8'h00,
    parameter logic [7:0]  LINE_RST = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output bank_t      bank
);

    bank_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (idx)
                IDX_BASE_HI: d.base[15:8] = wdata;
                IDX_BASE_LO: d.base[7:0]  = wdata;
                IDX_IRQ:     d.irq        = wdata & IRQ_MASK;
                IDX_LINE:    d.line       = wdata & LINE_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.base <= BASE_RST;
            q.irq  <= IRQ_RST & IRQ_MASK;
            q.line <= LINE_RST & LINE_MASK;
        end else begin
            q <= d;
        end
    end

    assign bank = q;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R4

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                 NCH       = 4,
    parameter logic [7:0]         KEY       = 8'h87,
    parameter logic [7:0]         EXIT_CODE = 8'hAA,
    parameter logic [15:0]        CHIP_ID   = 16'h1602,
    parameter logic [NCH*16-1:0]  BASE_RST  = {16'h02E8, 16'h03E8, 16'h02F8, 16'h03F8},
    parameter logic [NCH*8-1:0]   IRQ_RST   = {8'h00, 8'h10, 8'h20, 8'h30},
    parameter logic [NCH*8-1:0]   LINE_RST  = {8'h00, 8'h04, 8'h08, 8'h3C}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NCH*16-1:0] ch_base,
    output logic [NCH*8-1:0]  ch_irq,
    output logic [NCH*8-1:0]  ch_rs485
);

    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [7:0]       idx;
        logic [SEL_W-1:0] sel;
    } port_state_t;

    port_state_t q, d;

    logic  idx_wr, dat_wr, cfg_open, sel_ok;
    bank_t banks [NCH];
    bank_t cur;

    assign idx_wr = bus_wr && !bus_addr;
    assign dat_wr = bus_wr && bus_addr;

    sio_key_gate #(
        .KEY       (KEY),
        .EXIT_CODE (EXIT_CODE)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .any_wr   (bus_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open)
    );

    // pointer and channel selector
    always_comb begin
        d = q;
        if (cfg_open && idx_wr && bus_wdata != EXIT_CODE)
            d.idx = bus_wdata;
        if (cfg_open && dat_wr && q.idx == IDX_CHSEL)
            d.sel = bus_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // one register bank per channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
        logic bank_we;
        assign bank_we = cfg_open && dat_wr && (int'(q.sel) == ch);

        sio_dev_bank #(
            .BASE_RST (BASE_RST[ch*16 +: 16]),
            .IRQ_RST  (IRQ_RST[ch*8 +: 8]),
            .LINE_RST (LINE_RST[ch*8 +: 8])
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bank_we),
            .idx   (q.idx),
            .wdata (bus_wdata),
            .bank  (banks[ch])
        );

        assign ch_base[ch*16 +: 16] = banks[ch].base;
        assign ch_irq[ch*8 +: 8]    = banks[ch].irq;
        assign ch_rs485[ch*8 +: 8]  = banks[ch].line;
    end

    assign sel_ok = int'(q.sel) < NCH;

    always_comb begin
        cur = '0;
        if (sel_ok) cur = banks[q.sel];
    end

    // read path
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (!cfg_open) begin
                bus_rdata = LOCKED_READ;
            end else if (!bus_addr) begin
                bus_rdata = q.idx;
            end else begin
                case (q.idx)
                    IDX_CHSEL:   bus_rdata = 8'(q.sel);
                    IDX_CHIP_LO: bus_rdata = CHIP_ID[7:0];
                    IDX_CHIP_HI: bus_rdata = CHIP_ID[15:8];
                    IDX_VEND_A:  bus_rdata = VEND_A_VAL;
                    IDX_VEND_B:  bus_rdata = VEND_B_VAL;
                    IDX_BASE_HI: bus_rdata = cur.base[15:8];
                    IDX_BASE_LO: bus_rdata = cur.base[7:0];
                    IDX_IRQ:     bus_rdata = cur.irq;
                    IDX_LINE:    bus_rdata = cur.line;
                    default:     bus_rdata = 8'h00;
                endcase
            end
        end
    end

    AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd) |-> (bus_rdata == LOCKED_READ)); // R4

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(ch_base) && $stable(ch_irq) && $stable(ch_rs485))); // R4

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00)); // R12

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_open && dat_wr && q.idx == IDX_CHSEL) |=> $stable(q.sel)); // R7

    AST_EXIT_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_wdata == EXIT_CODE) |=> $stable(q.idx)); // R5

endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         NCH        = 4;
    localparam logic [7:0] KEY        = 8'h87;
    localparam logic [7:0] EXIT_CODE  = 8'hAA;
    localparam logic [15:0] CHIP_ID   = 16'h1602;
    localparam logic [NCH*16-1:0] BASE_RST = {16'h02E8, 16'h03E8, 16'h02F8, 16'h03F8};
    localparam logic [NCH*8-1:0]  IRQ_RST  = {8'h00, 8'h10, 8'h20, 8'h30};
    localparam logic [NCH*8-1:0]  LINE_RST = {8'h00, 8'h04, 8'h08, 8'h3C};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [NCH*16-1:0] ch_base;
    logic [NCH*8-1:0]  ch_irq, ch_rs485;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [15:0] m_base [NCH];
    logic [7:0]  m_irq  [NCH];
    logic [7:0]  m_line [NCH];
    int          m_sel;
    logic [7:0]  m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_port #(
        .NCH(NCH), .KEY(KEY), .EXIT_CODE(EXIT_CODE), .CHIP_ID(CHIP_ID),
        .BASE_RST(BASE_RST), .IRQ_RST(IRQ_RST), .LINE_RST(LINE_RST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_base(ch_base), .ch_irq(ch_irq), .ch_rs485(ch_rs485)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] ix);
        case (ix)
            8'h07:   return 8'(m_sel);
            8'h20:   return CHIP_ID[7:0];
            8'h21:   return CHIP_ID[15:8];
            8'h23:   return 8'h19;
            8'h24:   return 8'h34;
            8'h60:   return m_base[m_sel][15:8];
            8'h61:   return m_base[m_sel][7:0];
            8'h70:   return m_irq[m_sel];
            8'hF0:   return m_line[m_sel];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        for (int ch = 0; ch < NCH; ch++) begin
            check(req, ch_base[ch*16 +: 16], m_base[ch]);
            check(req, {8'h00, ch_irq[ch*8 +: 8]}, {8'h00, m_irq[ch]});
            check(req, {8'h00, ch_rs485[ch*8 +: 8]}, {8'h00, m_line[ch]});
        end
    endtask

    task automatic unlock();
        wr(0, KEY);
        wr(0, KEY);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int ch = 0; ch < NCH; ch++) begin
            m_base[ch] = BASE_RST[ch*16 +: 16];
            m_irq[ch]  = IRQ_RST[ch*8 +: 8] & 8'h70;
            m_line[ch] = LINE_RST[ch*8 +: 8] & 8'h3C;
        end
        m_sel = 0;
        m_idx = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R12 idle read data
        check("R1", ch_base[15:0], 16'h03F8);
        check_outputs("R1");
        #1 check("R12", {8'h00, bus_rdata}, 16'h0000);
        rd(1, v); check("R4 locked value read", {8'h00, v}, 16'h00FF);
        rd(0, v); check("R4 locked pointer read", {8'h00, v}, 16'h00FF);

        // R4 locked writes ignored
        wr(0, 8'h60); wr(1, 8'h55); wr(1, 8'h07);
        check_outputs("R4 locked write");

        // R2/R3 sweep of all 256 pointer bytes written twice
        for (int k = 0; k < 256; k++) begin
            wr(0, 8'(k)); wr(0, 8'(k));
            rd(1, v);
            if (8'(k) == KEY) begin
                check("R2 unlock", {8'h00, v}, {8'h00, exp_rd(m_idx)});
                wr(0, EXIT_CODE);
            end else begin
                check("R3 non-key", {8'h00, v}, 16'h00FF);
            end
        end

        // R3 key, other pointer, key: still locked; one more key opens
        wr(0, KEY); wr(0, 8'h00); wr(0, KEY);
        rd(1, v); check("R3 broken by pointer write", {8'h00, v}, 16'h00FF);
        wr(0, KEY);
        rd(0, v); check("R3 re-armed opens", {8'h00, v}, {8'h00, m_idx});
        wr(0, EXIT_CODE);
        // R3 key, value write, key: still locked
        wr(0, KEY); wr(1, 8'h12); wr(0, KEY);
        rd(1, v); check("R3 broken by value write", {8'h00, v}, 16'h00FF);
        wr(0, KEY); wr(0, EXIT_CODE);
        // R2 read between keys does not break
        wr(0, KEY); rd(1, v); wr(0, KEY);
        rd(0, v); check("R2 read between keys", {8'h00, v}, {8'h00, m_idx});
        check_outputs("R4 no change while locked");

        // R8 R9 R10 program every bank
        for (int ch = 0; ch < NCH; ch++) begin
            logic [15:0] b;
            logic [7:0] iw, lw;
            b  = 16'h1000 * 16'(ch + 1) + 16'h0123 * 16'(ch);
            iw = 8'hFF ^ 8'(ch * 8'h25);
            lw = 8'hA5 ^ 8'(ch * 8'h3B);
            wr(0, 8'h07); wr(1, 8'(ch)); m_sel = ch;
            wr(0, 8'h60); wr(1, b[15:8]);
            wr(0, 8'h61); wr(1, b[7:0]);
            wr(0, 8'h70); wr(1, iw);
            wr(0, 8'hF0); wr(1, lw);
            m_base[ch] = b;
            m_irq[ch]  = iw & 8'h70;
            m_line[ch] = lw & 8'h3C;
            m_idx = 8'hF0;
        end
        check_outputs("R8 R9 R10 exported");

        // R5 R6 R7 R8 R9 R10 R11 read every pointer in every bank
        for (int ch = 0; ch < NCH; ch++) begin
            wr(0, 8'h07); wr(1, 8'(ch)); m_sel = ch;
            for (int ix = 0; ix < 256; ix++) begin
                if (8'(ix) != EXIT_CODE) begin
                    wr(0, 8'(ix)); m_idx = 8'(ix);
                    rd(0, v); check("R5 pointer read", {8'h00, v}, {8'h00, m_idx});
                    rd(1, v); check("R11 R6 R8 R9 R10 sweep", {8'h00, v}, {8'h00, exp_rd(m_idx)});
                end
            end
        end

        // R6 identity writes ignored
        wr(0, 8'h20); wr(1, 8'h55);
        rd(1, v); check("R6 chip lo", {8'h00, v}, 16'h0002);
        wr(0, 8'h21); wr(1, 8'h00);
        rd(1, v); check("R6 chip hi", {8'h00, v}, 16'h0016);
        wr(0, 8'h24); wr(1, 8'h00);
        rd(1, v); check("R6 vendor b", {8'h00, v}, 16'h0034);
        check_outputs("R6 no bank change");

        // R7 only low two selector bits kept
        wr(0, 8'h07); wr(1, 8'hFE); m_sel = 2;
        rd(1, v); check("R7 selector", {8'h00, v}, 16'h0002);
        wr(0, 8'h60); m_idx = 8'h60;
        rd(1, v); check("R7 bank 2 picked", {8'h00, v}, {8'h00, m_base[2][15:8]});

        // R5 close and re-open keeps pointer
        wr(0, EXIT_CODE);
        rd(1, v); check("R5 locked after close", {8'h00, v}, 16'h00FF);
        wr(1, 8'h77);
        check_outputs("R4 write after close");
        unlock();
        rd(0, v); check("R5 pointer kept", {8'h00, v}, 16'h0060);
        #1 check("R12 idle", {8'h00, bus_rdata}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule